// File: doc/BRIEF.md
# Shared Memory Atomic Operation Unit

This block is a small word-addressed memory that several requester ports share, for example two processor cores. Every request is carried out as one indivisible read-modify-write step. Software can therefore build locks, counters and other synchronization objects on it. The operations are plain load, plain store, atomic exchange, test-and-set and fetch-and-increment, plus a load-linked / store-conditional pair that uses one reservation per port.

Each port has a valid/ready request channel that carries an opcode, a word address and write data. Each port also has a response channel that returns a data word one cycle after the request is accepted. When several ports ask in the same cycle, a round-robin arbiter accepts one of them. The read, the modify and the write of the chosen request all happen in that single cycle, so no other port can ever see a half-finished value.

The opcode encoding is 0 load, 1 store, 2 exchange, 3 test-and-set, 4 fetch-and-increment, 5 load-linked and 6 store-conditional. Code 7 behaves as a load.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads as 0, no response is valid, and no port holds a reservation.
- R2: A load (opcode 0) returns the addressed word and leaves memory unchanged. A store (opcode 1) writes the request data and returns the previous word.
- R3: An exchange (opcode 2) writes the request data into the word and returns its previous contents in the same step. When two ports both exchange 1 into a lock word that holds 0, exactly one of them gets 0 back and the other gets 1.
- R4: Test-and-set (opcode 3) returns the old word. It writes 1 only when the old word is 0, and otherwise leaves the word unchanged.
- R5: Fetch-and-increment (opcode 4) returns the old word and stores the old word plus one. All ones wraps to zero.
- R6: Load-linked (opcode 5) returns the word and reserves that address for the issuing port. A store-conditional (opcode 6) to the same address with the reservation still intact writes the data and returns 1.
- R7: If another port writes the linked address between a load-linked and the store-conditional, the store-conditional returns 0 and memory keeps the other port's value.
- R8: A store-conditional with no reservation, or with a reservation for a different address, returns 0 and writes nothing. Every store-conditional clears its own port's reservation, so a repeated one fails.
- R9: At most one request is accepted per cycle. A port that is not accepted keeps its request and is served in a later cycle. With all ports requesting, a port that was just accepted is not accepted again in the next cycle.
- R10: The response of a request is valid exactly in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NPORTS | Request valid, one bit per port |
| reqReady | output | NPORTS | Request accepted this cycle, one bit per port |
| reqOp | input | NPORTS*3 | Opcode per port |
| reqAddr | input | NPORTS*AW | Word address per port |
| reqData | input | NPORTS*DW | Write data per port |
| rspValid | output | NPORTS | Response valid per port |
| rspData | output | NPORTS*DW | Old word, or status 1/0 for store-conditional |

## Verification
Two functions can meet in a single cycle. The first is arbitration between ports that raise requests in the same cycle. The second is the atomic update of a word that both requests target. The bench raises exchange-of-1 requests on both ports at the same clock edge against a free lock word. It judges the result by three things: exactly one port reads 0, the two responses arrive one cycle apart, and the lock word ends at 1. Reservation loss is provoked by placing a store from the other port between a load-linked and its store-conditional. That case is judged by the status returned and by reading the word back.

// File: rtl/atom_pkg.sv
package atom_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4,
    OP_LINK  = 3'd5,
    OP_COND  = 3'd6,
    OP_RSVD  = 3'd7
  } atomOp_e;

  typedef enum logic [1:0] {WR_DATA, WR_INC, WR_ONE} wrSel_e;
  typedef enum logic [1:0] {RSP_OLD, RSP_PASS, RSP_FAIL} rspSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    fire;
    logic    wrEn;
    wrSel_e  wrSel;
    rspSel_e rspSel;
  } strobe_t;
endpackage

// File: rtl/atom_ctrl.sv
module atom_ctrl
  import atom_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int AW     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    reqValid,
  input  logic [NPORTS*3-1:0]  reqOp,
  input  logic [NPORTS*AW-1:0] reqAddr,
  input  logic                 oldIsZero,
  output logic [NPORTS-1:0]    grantVec,
  output strobe_t              strobe
);
  localparam int IDXW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  logic [IDXW-1:0]   lastGrant;
  logic [IDXW-1:0]   selIdx;
  logic              anyReq;
  atomOp_e           selOp;
  logic [AW-1:0]     selAddr;
  logic [NPORTS-1:0] resValid;
  logic [AW-1:0]     resAddr [NPORTS];
  logic              condPass;

  // round-robin pick starting after the last granted port
  always_comb begin
    grantVec = '0;
    selIdx   = '0;
    anyReq   = 1'b0;
    for (int k = 1; k <= NPORTS; k++) begin
      int idx;
      idx = (int'(lastGrant) + k) % NPORTS;
      if (!anyReq && reqValid[idx]) begin
        anyReq        = 1'b1;
        selIdx        = IDXW'(idx);
        grantVec[idx] = 1'b1;
      end
    end
  end

  always_comb begin
    selOp   = OP_LOAD;
    selAddr = '0;
    for (int k = 0; k < NPORTS; k++) begin
      if (grantVec[k]) begin
        selOp   = atomOp_e'(reqOp[k*3 +: 3]);
        selAddr = reqAddr[k*AW +: AW];
      end
    end
  end

  assign condPass = resValid[selIdx] && (resAddr[selIdx] == selAddr);

  always_comb begin
    strobe        = '0;
    strobe.fire   = anyReq;
    strobe.wrSel  = WR_DATA;
    strobe.rspSel = RSP_OLD;
    unique case (selOp)
      OP_STORE, OP_SWAP: strobe.wrEn = anyReq;
      OP_TAS: begin
        strobe.wrEn  = anyReq && oldIsZero;
        strobe.wrSel = WR_ONE;
      end
      OP_FINC: begin
        strobe.wrEn  = anyReq;
        strobe.wrSel = WR_INC;
      end
      OP_COND: begin
        strobe.wrEn   = anyReq && condPass;
        strobe.rspSel = condPass ? RSP_PASS : RSP_FAIL;
      end
      default: strobe.wrEn = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastGrant <= IDXW'(NPORTS - 1);
      resValid  <= '0;
      for (int p = 0; p < NPORTS; p++) resAddr[p] <= '0;
    end else if (anyReq) begin
      lastGrant <= selIdx;
      for (int p = 0; p < NPORTS; p++) begin
        if (IDXW'(p) == selIdx) begin
          if (selOp == OP_LINK) begin
            resValid[p] <= 1'b1;
            resAddr[p]  <= selAddr;
          end else if (selOp == OP_COND) begin
            resValid[p] <= 1'b0;
          end
        end else if (strobe.wrEn && resAddr[p] == selAddr) begin
          resValid[p] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/atom_datapath.sv
module atom_datapath
  import atom_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    grantVec,
  input  strobe_t              strobe,
  input  logic [NPORTS*AW-1:0] reqAddr,
  input  logic [NPORTS*DW-1:0] reqData,
  output logic                 oldIsZero,
  output logic [NPORTS-1:0]    rspValid,
  output logic [NPORTS*DW-1:0] rspData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] selAddr;
  logic [DW-1:0] selData;
  logic [DW-1:0] oldWord;
  logic [DW-1:0] newWord;
  logic [DW-1:0] rspWord;

  always_comb begin
    selAddr = '0;
    selData = '0;
    for (int k = 0; k < NPORTS; k++) begin
      if (grantVec[k]) begin
        selAddr = reqAddr[k*AW +: AW];
        selData = reqData[k*DW +: DW];
      end
    end
  end

  assign oldWord   = mem[selAddr];
  assign oldIsZero = (oldWord == '0);

  always_comb begin
    unique case (strobe.wrSel)
      WR_INC:  newWord = oldWord + DW'(1);
      WR_ONE:  newWord = DW'(1);
      default: newWord = selData;
    endcase
    unique case (strobe.rspSel)
      RSP_PASS: rspWord = DW'(1);
      RSP_FAIL: rspWord = '0;
      default:  rspWord = oldWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.wrEn) begin
      mem[selAddr] <= newWord;
    end
  end

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_rsp
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rspValid[p]          <= 1'b0;
          rspData[p*DW +: DW]  <= '0;
        end else begin
          rspValid[p] <= grantVec[p];
          if (grantVec[p]) rspData[p*DW +: DW] <= rspWord;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import atom_pkg::*;
#(
  parameter int NPORTS = 2,
  parameter int AW     = 4,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    reqValid,
  output logic [NPORTS-1:0]    reqReady,
  input  logic [NPORTS*3-1:0]  reqOp,
  input  logic [NPORTS*AW-1:0] reqAddr,
  input  logic [NPORTS*DW-1:0] reqData,
  output logic [NPORTS-1:0]    rspValid,
  output logic [NPORTS*DW-1:0] rspData
);
  logic [NPORTS-1:0] grantVec;
  strobe_t           strobe;
  logic              oldIsZero;

  atom_ctrl #(.NPORTS(NPORTS), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .reqAddr   (reqAddr),
    .oldIsZero (oldIsZero),
    .grantVec  (grantVec),
    .strobe    (strobe)
  );

  atom_datapath #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .grantVec  (grantVec),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqData   (reqData),
    .oldIsZero (oldIsZero),
    .rspValid  (rspValid),
    .rspData   (rspData)
  );

  assign reqReady = grantVec;
endmodule

// File: rtl/atomic_mem_checker.sv
module atomic_mem_checker #(
  parameter int NPORTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] reqValid,
  input logic [NPORTS-1:0] reqReady,
  input logic [NPORTS-1:0] rspValid
);
  // R9: a single acceptance per cycle
  p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqReady));

  generate
    for (genvar i = 0; i < NPORTS; i++) begin : g_port
      // R9: acceptance only for a requesting port
      p_ready_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reqReady[i] |-> reqValid[i]);
      // R9: with every port requesting, no port wins twice in a row
      p_rotate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reqReady[i] && (&reqValid) && NPORTS > 1) |=> !((&reqValid) && reqReady[i]));
      // R10: response in the cycle after acceptance
      p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reqReady[i] |=> rspValid[i]);
      // R10: no response without an acceptance the cycle before
      p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !reqReady[i] |=> !rspValid[i]);
    end
  endgenerate
endmodule

bind atomic_mem_unit atomic_mem_checker #(.NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid)
);

// File: tb/atomic_mem_unit_bench.sv
module atomic_mem_unit_bench;
  localparam int PERIOD = 10;
  localparam int NP = 2;
  localparam int AW = 4;
  localparam int DW = 8;

  localparam logic [2:0] LOAD = 3'd0, STORE = 3'd1, SWAP = 3'd2, TAS = 3'd3,
                         FINC = 3'd4, LINK = 3'd5, COND = 3'd6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     reqValid = '0;
  logic [NP-1:0]     reqReady;
  logic [NP*3-1:0]   reqOp = '0;
  logic [NP*AW-1:0]  reqAddr = '0;
  logic [NP*DW-1:0]  reqData = '0;
  logic [NP-1:0]     rspValid;
  logic [NP*DW-1:0]  rspData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  atomic_mem_unit #(.NPORTS(NP), .AW(AW), .DW(DW)) u_atomic_mem_unit (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one request on one port; waits for acceptance and returns the response
  task automatic txn(input int p, input logic [2:0] o, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, output logic [DW-1:0] r);
    @(negedge clk);
    reqValid[p] = 1'b1;
    reqOp[p*3 +: 3]   = o;
    reqAddr[p*AW +: AW] = a;
    reqData[p*DW +: DW] = d;
    #1;
    while (!reqReady[p]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    chk("R10 response valid after accept", DW'(rspValid[p]), DW'(1));
    r = rspData[p*DW +: DW];
    reqValid[p] = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] r;
    chk("R1 no response after reset", DW'(rspValid), '0);
    chk("R1 no accept when idle", DW'(reqReady), '0);
    txn(0, LOAD, 4'd0, 8'h00, r);  chk("R1 word 0 cleared", r, 8'h00);
    txn(1, LOAD, 4'd15, 8'h00, r); chk("R1 word 15 cleared", r, 8'h00);
    txn(0, COND, 4'd2, 8'h44, r);  chk("R1 no reservation after reset", r, 8'h00);
    txn(0, LOAD, 4'd2, 8'h00, r);  chk("R1 failed cond left word", r, 8'h00);
  endtask

  task automatic t_load_store();
    logic [DW-1:0] r;
    txn(0, STORE, 4'd1, 8'hA5, r); chk("R2 store returns previous", r, 8'h00);
    txn(1, LOAD, 4'd1, 8'h00, r);  chk("R2 load sees store", r, 8'hA5);
    txn(1, LOAD, 4'd1, 8'h00, r);  chk("R2 load leaves word", r, 8'hA5);
  endtask

  task automatic t_swap();
    logic [DW-1:0] r;
    txn(0, STORE, 4'd4, 8'h3C, r);
    txn(1, SWAP, 4'd4, 8'h77, r);  chk("R3 exchange returns old", r, 8'h3C);
    txn(0, LOAD, 4'd4, 8'h00, r);  chk("R3 exchange wrote new", r, 8'h77);
  endtask

  // both ports exchange 1 into a free lock word in the same cycle
  task automatic t_lock_race();
    logic [DW-1:0] res [NP];
    int when [NP];
    bit got [NP];
    logic [NP-1:0] rdy;
    logic [DW-1:0] r;
    txn(0, STORE, 4'd3, 8'h00, r);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      reqValid[p] = 1'b1;
      reqOp[p*3 +: 3] = SWAP;
      reqAddr[p*AW +: AW] = 4'd3;
      reqData[p*DW +: DW] = 8'h01;
      got[p] = 0; when[p] = 0; res[p] = '0;
    end
    for (int cyc = 0; cyc < 6; cyc++) begin
      #1;
      rdy = reqReady;
      chk("R9 at most one accept", DW'($countones(rdy) <= 1), DW'(1));
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        if (rspValid[p]) begin
          got[p] = 1; res[p] = rspData[p*DW +: DW]; when[p] = cyc;
        end
        if (rdy[p]) reqValid[p] = 1'b0;
      end
    end
    chk("R9 both ports served", DW'(got[0] && got[1]), DW'(1));
    chk("R3 exactly one lock winner",
        DW'((res[0] == 8'h00 && res[1] == 8'h01) || (res[0] == 8'h01 && res[1] == 8'h00)), DW'(1));
    chk("R9 loser held and served next cycle",
        DW'((when[0] - when[1] == 1) || (when[1] - when[0] == 1)), DW'(1));
    txn(0, LOAD, 4'd3, 8'h00, r); chk("R3 lock word held", r, 8'h01);
  endtask

  task automatic t_tas();
    logic [DW-1:0] r;
    txn(0, TAS, 4'd9, 8'h00, r);   chk("R4 tas on free returns 0", r, 8'h00);
    txn(1, LOAD, 4'd9, 8'h00, r);  chk("R4 tas set word", r, 8'h01);
    txn(1, TAS, 4'd9, 8'h00, r);   chk("R4 tas on held returns 1", r, 8'h01);
    txn(0, STORE, 4'd9, 8'h05, r);
    txn(0, TAS, 4'd9, 8'h00, r);   chk("R4 tas returns nonzero old", r, 8'h05);
    txn(1, LOAD, 4'd9, 8'h00, r);  chk("R4 failed test leaves word", r, 8'h05);
  endtask

  task automatic t_finc();
    logic [DW-1:0] r;
    txn(0, STORE, 4'd10, 8'hFE, r);
    txn(1, FINC, 4'd10, 8'h00, r); chk("R5 finc returns old", r, 8'hFE);
    txn(0, FINC, 4'd10, 8'h00, r); chk("R5 finc at all ones", r, 8'hFF);
    txn(1, LOAD, 4'd10, 8'h00, r); chk("R5 finc wraps to zero", r, 8'h00);
  endtask

  task automatic t_llsc_ok();
    logic [DW-1:0] r;
    txn(0, STORE, 4'd6, 8'h11, r);
    txn(0, LINK, 4'd6, 8'h00, r);  chk("R6 link returns word", r, 8'h11);
    txn(1, LOAD, 4'd6, 8'h00, r);
    txn(0, COND, 4'd6, 8'h22, r);  chk("R6 cond succeeds", r, 8'h01);
    txn(1, LOAD, 4'd6, 8'h00, r);  chk("R6 cond wrote word", r, 8'h22);
    txn(0, COND, 4'd6, 8'h33, r);  chk("R8 repeated cond fails", r, 8'h00);
    txn(1, LOAD, 4'd6, 8'h00, r);  chk("R8 repeated cond no write", r, 8'h22);
  endtask

  task automatic t_llsc_broken();
    logic [DW-1:0] r;
    txn(0, LINK, 4'd5, 8'h00, r);
    txn(1, STORE, 4'd5, 8'h99, r);
    txn(0, COND, 4'd5, 8'h42, r);  chk("R7 cond after foreign store fails", r, 8'h00);
    txn(1, LOAD, 4'd5, 8'h00, r);  chk("R7 foreign value kept", r, 8'h99);
    txn(1, LINK, 4'd12, 8'h00, r);
    txn(0, FINC, 4'd12, 8'h00, r);
    txn(1, COND, 4'd12, 8'h50, r); chk("R7 cond after foreign finc fails", r, 8'h00);
  endtask

  task automatic t_llsc_wrong_addr();
    logic [DW-1:0] r;
    txn(1, STORE, 4'd8, 8'h0D, r);
    txn(1, LINK, 4'd7, 8'h00, r);
    txn(1, COND, 4'd8, 8'hEE, r);  chk("R8 cond to other address fails", r, 8'h00);
    txn(0, LOAD, 4'd8, 8'h00, r);  chk("R8 other address unchanged", r, 8'h0D);
    txn(1, COND, 4'd7, 8'hEE, r);  chk("R8 reservation cleared by failed cond", r, 8'h00);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_store();
    t_swap();
    t_lock_race();
    t_tas();
    t_finc();
    t_llsc_ok();
    t_llsc_broken();
    t_llsc_wrong_addr();
    t_lock_race();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule